// File: doc/BRIEF.md
# Radix-4 SRT Quotient Digit Selector

This block picks the next quotient digit for a radix-4 SRT divider. Each step, the divider forms a short estimate of its partial remainder and shows it together with the leading fraction bits of the normalized divisor. The selector answers with a digit in {-2, -1, 0, +1, +2}. The remainder datapath uses a redundant carry-save form, so the truncated estimate can sit one cell below the true remainder. Every answer therefore holds for the indexed cell and for the cell directly above it.

No table is stored. The digit comes from logic that tests the containment bound of each candidate magnitude against the worst corner of the cell. That cell spans one divisor step in width and the remainder range the estimate may stand for. The smallest legal magnitude wins. Cells the divider can never reach return magnitude 2, so a forgotten corner can never fall back to zero.

The block is purely combinational and has no clock.

Top module: `srt_qdigit_table`

## Requirements
- R1: The remainder estimate `rem_est_i` is a 7-bit two's-complement value in units of 1/8 (range -8 to 7.875). The divisor is 1 + `div_frac_i`/16, whose leading one is implied. The outputs depend only on the present inputs.
- R2: The magnitude is encoded as `mag_one_o` for magnitude 1 and `mag_two_o` for magnitude 2. The two are never set together, and both clear means digit 0.
- R3: `dig_neg_o` is set exactly when bit 6 of `rem_est_i` is set and the magnitude is non-zero. The digit sign follows the estimate sign.
- R4: This requirement covers every reachable cell. Take a true remainder p in [P/8, P/8 + 1/4] and a divisor D in [1 + d/16, 1 + (d+1)/16], where the point meets |p| ≤ 8/3·D. The digit k returned for that cell satisfies (k - 2/3)·D ≤ p ≤ (k + 2/3)·D at every such point.
- R5: Where magnitude 0 is legal over the whole cell, 0 is returned. Otherwise magnitude 1 is returned where it is legal over the whole cell. Magnitude 2 is used only when neither of these holds.
- R6: A cell in which no point meets |p| ≤ 8/3·D returns magnitude 2 with the estimate's sign.
- R7: The cell bounds allow for an estimate one cell low. With divisor fraction 0, the positive digit switches from +1 to +2 between estimates 11/8 and 12/8. The negative digit switches from 0 to -1 between -5/8 and -6/8, and from -1 to -2 between -13/8 and -14/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rem_est_i | input | 7 | Truncated partial remainder estimate, two's complement, 3 fraction bits |
| div_frac_i | input | 4 | Divisor fraction bits below the implied leading one |
| mag_one_o | output | 1 | Digit magnitude is 1 |
| mag_two_o | output | 1 | Digit magnitude is 2 |
| dig_neg_o | output | 1 | Digit is negative |

## Verification
The hardest cells to reach are the few on the slanted bounds. There, the extra cell of slack decides between two magnitudes. The cells just inside the unreachable corners are equally hard, because a zero there would be fatal. A divider running real operands lands in them only rarely. The bench therefore drives the index directly and sweeps all 2048 cells. It judges each answer against rational bounds scaled to integers and sampled on a 1/48 grid over the whole cell. It then revisits the named switch points one by one.

// File: rtl/srt_qsel_pkg.sv
package srt_qsel_pkg;

    // Signed digit as two magnitude flags plus a sign
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } qdigit_t;

    // Scaled bound test: coef/3 * D <= p, with D = dn / 2^DF and p = pe / 2^PF.
    // Both sides are brought to a common scale: dsc = 2^PF, psc = 3 * 2^DF.
    function automatic logic lower_holds(input int coef, input int dn, input int pe,
                                         input int dsc, input int psc);
        return (coef * dn * dsc) <= (pe * psc);
    endfunction

    function automatic logic upper_holds(input int coef, input int dn, input int pe,
                                         input int dsc, input int psc);
        return (pe * psc) <= (coef * dn * dsc);
    endfunction

endpackage

// File: rtl/srt_digit_window.sv
// Tests whether digit magnitude MAG, carrying the sign of the estimate, is legal
// over the whole cell: divisor step [dn, dn+1] and true remainder [P, P+1+SHORT].
// With SKIP_OUTER set, the bound facing away from zero is not tested; reachable
// points never cross it for the largest magnitude.
module srt_digit_window
    import srt_qsel_pkg::*;
#(
    parameter int P_W        = 7,
    parameter int P_FRAC     = 3,
    parameter int D_W        = 4,
    parameter int SHORT      = 1,
    parameter int MAG        = 0,
    parameter bit SKIP_OUTER = 1'b0
) (
    input  logic [P_W-1:0] rem_est,
    input  logic [D_W-1:0] div_frac,
    output logic           legal
);
    localparam int DSC = 1 << P_FRAC;
    localparam int PSC = 3 << D_W;
    localparam int ONE = 1 << D_W;

    typedef struct packed {
        int p_lo;
        int p_hi;
        int dn_lo;
        int dn_hi;
        int k;
        int c_lo;
        int c_hi;
        int dn_for_lo;
        int dn_for_hi;
        logic lo_ok;
        logic hi_ok;
        logic ok;
    } win_t;

    win_t win_d;

    always_comb begin
        win_d       = '0;
        win_d.p_lo  = int'($signed(rem_est));
        win_d.p_hi  = win_d.p_lo + 1 + SHORT;
        win_d.dn_lo = ONE + int'(div_frac);
        win_d.dn_hi = win_d.dn_lo + 1;
        win_d.k     = rem_est[P_W-1] ? -MAG : MAG;
        win_d.c_lo  = 3 * win_d.k - 2;
        win_d.c_hi  = 3 * win_d.k + 2;
        // The binding divisor corner depends on the sign of the bound slope
        win_d.dn_for_lo = (win_d.c_lo > 0) ? win_d.dn_hi : win_d.dn_lo;
        win_d.dn_for_hi = (win_d.c_hi > 0) ? win_d.dn_lo : win_d.dn_hi;
        win_d.lo_ok = lower_holds(win_d.c_lo, win_d.dn_for_lo, win_d.p_lo, DSC, PSC);
        win_d.hi_ok = upper_holds(win_d.c_hi, win_d.dn_for_hi, win_d.p_hi, DSC, PSC);
        if (SKIP_OUTER) begin
            if (rem_est[P_W-1]) win_d.lo_ok = 1'b1;
            else                win_d.hi_ok = 1'b1;
        end
        win_d.ok = win_d.lo_ok & win_d.hi_ok;
    end

    assign legal = win_d.ok;

endmodule

// File: rtl/srt_reach_check.sv
// A cell is reachable when some point in it meets |p| <= 8/3 * D.
module srt_reach_check
    import srt_qsel_pkg::*;
#(
    parameter int P_W    = 7,
    parameter int P_FRAC = 3,
    parameter int D_W    = 4,
    parameter int SHORT  = 1
) (
    input  logic [P_W-1:0] rem_est,
    input  logic [D_W-1:0] div_frac,
    output logic           reach
);
    localparam int DSC = 1 << P_FRAC;
    localparam int PSC = 3 << D_W;
    localparam int ONE = 1 << D_W;

    typedef struct packed {
        int   p_lo;
        int   p_hi;
        int   dn_hi;
        logic ok;
    } rch_t;

    rch_t rch_d;

    always_comb begin
        rch_d       = '0;
        rch_d.p_lo  = int'($signed(rem_est));
        rch_d.p_hi  = rch_d.p_lo + 1 + SHORT;
        rch_d.dn_hi = ONE + int'(div_frac) + 1;
        // The widest divisor gives the loosest limit in both directions
        if (rem_est[P_W-1])
            rch_d.ok = lower_holds(-8, rch_d.dn_hi, rch_d.p_hi, DSC, PSC);
        else
            rch_d.ok = upper_holds(8, rch_d.dn_hi, rch_d.p_lo, DSC, PSC);
    end

    assign reach = rch_d.ok;

endmodule

// File: rtl/srt_digit_pick.sv
// Chooses the smallest legal magnitude; unreachable cells fall to magnitude 2.
module srt_digit_pick
    import srt_qsel_pkg::*;
(
    input  logic [2:0] mag_legal,
    input  logic       reach,
    input  logic       est_neg,
    output qdigit_t    digit
);
    qdigit_t pick_d;

    always_comb begin
        pick_d = '0;
        if (!reach) begin
            pick_d.two = 1'b1;
        end else if (mag_legal[0]) begin
            pick_d.two = 1'b0;
        end else if (mag_legal[1]) begin
            pick_d.one = 1'b1;
        end else begin
            pick_d.two = 1'b1;
        end
        pick_d.neg = est_neg & (pick_d.one | pick_d.two);
    end

    assign digit = pick_d;

    always_comb begin
        // R2: flags never both set
        a_r2_mag_onehot: assert ($onehot0({digit.one, digit.two}))
            else $error("R2: both magnitude flags set");
        // R4: a reachable cell always gets a digit whose window holds
        a_r4_legal_digit: assert (!reach || (digit.one ? mag_legal[1] :
                                             digit.two ? mag_legal[2] : mag_legal[0]))
            else $error("R4: selected digit outside its bounds");
        // R5: a larger magnitude only when the smaller ones fail
        a_r5_min_mag: assert (!(reach && (digit.one || digit.two)) || !mag_legal[0])
            else $error("R5: non-zero digit where zero was legal");
        // R6: unreachable cells never read as zero
        a_r6_fill_two: assert (reach || digit.two)
            else $error("R6: unreachable cell not magnitude 2");
        // R3: sign only on a non-zero digit and only for a negative estimate
        a_r3_sign: assert (!digit.neg || (est_neg && (digit.one || digit.two)))
            else $error("R3: sign flag inconsistent");
    end

endmodule

// File: rtl/srt_qdigit_table.sv
module srt_qdigit_table
    import srt_qsel_pkg::*;
#(
    parameter int P_W    = 7,
    parameter int P_FRAC = 3,
    parameter int D_W    = 4,
    parameter int SHORT  = 1
) (
    input  logic [P_W-1:0] rem_est_i,
    input  logic [D_W-1:0] div_frac_i,
    output logic           mag_one_o,
    output logic           mag_two_o,
    output logic           dig_neg_o
);
    localparam int N_MAG = 3;

    logic [N_MAG-1:0] mag_legal;
    logic             reach;
    qdigit_t          digit;

    for (genvar m = 0; m < N_MAG; m++) begin : g_win
        srt_digit_window #(
            .P_W       (P_W),
            .P_FRAC    (P_FRAC),
            .D_W       (D_W),
            .SHORT     (SHORT),
            .MAG       (m),
            .SKIP_OUTER(m == N_MAG - 1)
        ) u_win (
            .rem_est (rem_est_i),
            .div_frac(div_frac_i),
            .legal   (mag_legal[m])
        );
    end

    srt_reach_check #(
        .P_W   (P_W),
        .P_FRAC(P_FRAC),
        .D_W   (D_W),
        .SHORT (SHORT)
    ) u_reach (
        .rem_est (rem_est_i),
        .div_frac(div_frac_i),
        .reach   (reach)
    );

    srt_digit_pick u_pick (
        .mag_legal(mag_legal),
        .reach    (reach),
        .est_neg  (rem_est_i[P_W-1]),
        .digit    (digit)
    );

    assign mag_one_o = digit.one;
    assign mag_two_o = digit.two;
    assign dig_neg_o = digit.neg;

    always_comb begin
        // R1: a non-negative estimate never yields a negative digit
        a_r1_sign_source: assert (rem_est_i[P_W-1] || !dig_neg_o)
            else $error("R1: negative digit from non-negative estimate");
    end

endmodule

// File: tb/sim_srt_qdigit_table.sv
module sim_srt_qdigit_table;

    logic       clk = 1'b0;
    logic [6:0] rem_est;
    logic [3:0] div_frac;
    logic       mag_one, mag_two, dig_neg;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    srt_qdigit_table u0 (
        .rem_est_i (rem_est),
        .div_frac_i(div_frac),
        .mag_one_o (mag_one),
        .mag_two_o (mag_two),
        .dig_neg_o (dig_neg)
    );

    // All quantities on a 1/48 grid: p48 = 48*p, d48 = 48*D
    function automatic bit win_ok(int k, int p48, int d48);
        return ((3*k - 2) * d48 <= 3 * p48) && (3 * p48 <= (3*k + 2) * d48);
    endfunction

    function automatic bit pt_reach(int p48, int d48);
        return (3 * p48 <= 8 * d48) && (3 * p48 >= -8 * d48);
    endfunction

    function automatic bit cell_ok(int k, int pc, int dc, bit clip);
        for (int p48 = 6*pc; p48 <= 6*pc + 12; p48++)
            for (int d48 = 48 + 3*dc; d48 <= 51 + 3*dc; d48++) begin
                if (clip && !pt_reach(p48, d48)) continue;
                if (!win_ok(k, p48, d48)) return 1'b0;
            end
        return 1'b1;
    endfunction

    function automatic bit cell_reach(int pc, int dc);
        for (int p48 = 6*pc; p48 <= 6*pc + 12; p48++)
            for (int d48 = 48 + 3*dc; d48 <= 51 + 3*dc; d48++)
                if (pt_reach(p48, d48)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int model_digit(int pc, int dc);
        int sg = (pc < 0) ? -1 : 1;
        if (!cell_reach(pc, dc))        return 2 * sg;
        if (cell_ok(0, pc, dc, 1'b0))   return 0;
        if (cell_ok(sg, pc, dc, 1'b0))  return sg;
        return 2 * sg;
    endfunction

    function automatic int seen_digit();
        int m = mag_one ? 1 : (mag_two ? 2 : 0);
        return dig_neg ? -m : m;
    endfunction

    task automatic apply(input int pc, input int dc);
        @(posedge clk);
        rem_est  <= 7'(pc);
        div_frac <= 4'(dc);
        @(negedge clk);
    endtask

    task automatic fail(input string req, input int pc, input int dc,
                        input int got, input int exp);
        n_fail++;
        $display("FAIL %s p=%0d/8 d=%0d got=%0d exp=%0d", req, pc, dc, got, exp);
    endtask

    // Full comparison of one cell against the model
    task automatic judge(input int pc, input int dc, input string tag);
        int exp = model_digit(pc, dc);
        int got = seen_digit();
        n_vec++;
        if (mag_one && mag_two) fail({tag, " R2"}, pc, dc, 3, exp);
        else if (dig_neg != ((pc < 0) && (got != 0)))
            fail({tag, " R3"}, pc, dc, int'(dig_neg), int'((pc < 0) && (exp != 0)));
        else if (cell_reach(pc, dc) && !cell_ok(got, pc, dc, 1'b1))
            fail({tag, " R4"}, pc, dc, got, exp);
        else if (got != exp) fail({tag, " R5/R6"}, pc, dc, got, exp);
    endtask

    task automatic expect_digit(input int pc, input int dc, input int exp, input string req);
        int got;
        apply(pc, dc);
        got = seen_digit();
        n_vec++;
        if (got != exp) fail(req, pc, dc, got, exp);
    endtask

    initial begin
        rem_est  = '0;
        div_frac = '0;
        // R1: reset-time state, estimate 0 divisor 1.0 gives digit 0
        @(negedge clk);
        n_vec++;
        if (mag_one || mag_two || dig_neg) fail("R1 idle", 0, 0, seen_digit(), 0);

        // R4/R5/R6: every index combination
        for (int i = 0; i < 2048; i++) begin
            int pc = (i >> 4) - 64;
            int dc = i & 15;
            apply(pc, dc);
            judge(pc, dc, "sweep");
        end

        // R7: switch points shifted by the one-cell slack
        expect_digit(11, 0, 1, "R7 pos 1/2 below");
        expect_digit(12, 0, 2, "R7 pos 1/2 above");
        expect_digit(-5, 0, 0, "R7 neg 0/1 above");
        expect_digit(-6, 0, -1, "R7 neg 0/1 below");
        expect_digit(-13, 0, -1, "R7 neg 1/2 above");
        expect_digit(-14, 0, -2, "R7 neg 1/2 below");
        // R5: zero kept while legal
        expect_digit(3, 0, 0, "R5 zero edge");
        expect_digit(4, 0, 1, "R5 one edge");
        // R6: unreachable corners hold magnitude 2
        expect_digit(63, 15, 2, "R6 top corner");
        expect_digit(-64, 0, -2, "R6 bottom corner");
        // R3: estimate -1/8 gives an unsigned zero
        expect_digit(-1, 5, 0, "R3 neg zero");
        // R1: output follows the inputs alone, return to the same cell
        expect_digit(11, 0, 1, "R1 revisit");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 got=hang exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule